// File: doc/BRIEF.md
# Eight-Slot Memory Paging Unit

This unit translates a 16-bit CPU address into a physical memory location. The CPU space is cut into eight 8 KB windows. Address bits 15 to 13 pick a window, and each window has its own page register. The physical address is that page number placed in front of CPU address bits 12 to 0. For every requested access the unit raises one of three flags: a RAM select for a valid page, a ROM select when the page value 255 sits in one of the two lowest windows, or an unmapped flag for every other page value.

Software reaches the page registers through an indexed port. A 3-bit index picks the window, a write strobe loads a new page, and the read data always shows the page stored in the indexed window. A second write path stands for the older 16 KB banking scheme. A write on that path loads page 255 into windows 0 and 1. It also loads the two 8 KB halves of the chosen 16 KB bank into windows 6 and 7, and software can read those values back afterwards.

Top module: `slot_pager`

## Requirements
- R1: For an access, the window is cpu_addr[15:13]. phys_addr is the 8-bit page of that window followed by cpu_addr[12:0], giving {page, offset} with the page in bits 20:13.
- R2: After a synchronous reset the windows 0 to 7 hold the pages 255, 255, 10, 11, 4, 5, 0 and 1.
- R3: When reg_wr is high, reg_wdata is stored into window reg_idx on the clock edge. No window changes in a cycle with neither write strobe. reg_rdata always shows, without delay, the stored page of window reg_idx.
- R4: When cpu_req is high, the selected window is 0 or 1, and its page is 255, rom_sel is high and ram_sel and unmapped are low.
- R5: When cpu_req is high and the selected page is 0 to 223, ram_sel is high and rom_sel and unmapped are low.
- R6: When cpu_req is high and the selected page is 224 to 254 in any window, or 255 in windows 2 to 7, unmapped is high and ram_sel and rom_sel are low.
- R7: When leg_wr is high with bank b = leg_bank, the edge stores 255 in windows 0 and 1, 2b in window 6 and 2b+1 in window 7. Windows 2 to 5 are left unchanged.
- R8: If reg_wr and leg_wr are high in the same cycle, the legacy values win in windows 0, 1, 6 and 7. An indexed write aimed at windows 2 to 5 still takes effect.
- R9: When cpu_req is low, ram_sel, rom_sel and unmapped are all low.
- R10: Pages loaded by a legacy write read back through reg_rdata in the same way as pages loaded through the indexed port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Indexed page write strobe |
| reg_idx | input | 3 | Window selected for indexed write and readback |
| reg_wdata | input | 8 | Page value for indexed write |
| reg_rdata | output | 8 | Stored page of window reg_idx |
| leg_wr | input | 1 | Legacy 16 KB bank write strobe |
| leg_bank | input | 7 | 16 KB bank number for legacy write |
| cpu_req | input | 1 | CPU access valid |
| cpu_addr | input | 16 | CPU address |
| phys_addr | output | 21 | Physical address {page, offset} |
| ram_sel | output | 1 | Access goes to RAM |
| rom_sel | output | 1 | Access goes to ROM |
| unmapped | output | 1 | Access hits no memory |

## Verification
The bench builds the unit with its default sizes: eight windows, 8-bit pages and a 16-bit CPU address. With those sizes every page code from 0 to 255 can be driven. That includes the edge between 223 and 224, the band from 224 to 254, and the value 255 in both the ROM windows and the RAM windows. Legacy bank numbers run up to 127, so the top pair of pages, 254 and 255, is also reached through the mirror path. A behavioural model is updated each clock and compared against the readback and every translation output on every clock, over directed collision cases and a long run of mixed random traffic.

// File: rtl/slot_pager_pkg.sv
package slot_pager_pkg;

    localparam int SLOT_CNT   = 8;
    localparam int PAGE_W     = 8;
    localparam int CPU_AW     = 16;
    localparam int SLOT_W     = $clog2(SLOT_CNT);
    localparam int OFFS_W     = CPU_AW - SLOT_W;
    localparam int PHYS_W     = PAGE_W + OFFS_W;
    localparam int BANK_W     = PAGE_W - 1;
    localparam int RAM_PAGES  = 224;
    localparam int ROM_PAGE   = (1 << PAGE_W) - 1;
    localparam int ROM_SLOTS  = 2;
    localparam int MIRROR_LO  = 6;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SLOT_CNT-1:0][PAGE_W-1:0] page_vec_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RAM  = 2'd1,
        ACC_ROM  = 2'd2,
        ACC_BAD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        page_t             page;
        logic [OFFS_W-1:0] offs;
    } phys_t;

    function automatic page_t reset_page(input int slot);
        case (slot)
            0, 1:    return page_t'(ROM_PAGE);
            2:       return page_t'(10);
            3:       return page_t'(11);
            4:       return page_t'(4);
            5:       return page_t'(5);
            6:       return page_t'(0);
            default: return page_t'(1);
        endcase
    endfunction

    function automatic page_vec_t reset_image();
        page_vec_t v;
        for (int s = 0; s < SLOT_CNT; s++) v[s] = reset_page(s);
        return v;
    endfunction

    function automatic acc_kind_e classify(input page_t pg, input logic rom_slot);
        if (int'(pg) < RAM_PAGES)                  return ACC_RAM;
        else if (int'(pg) == ROM_PAGE && rom_slot) return ACC_ROM;
        else                                       return ACC_BAD;
    endfunction

endpackage

// File: rtl/bank_mirror.sv
module bank_mirror
    import slot_pager_pkg::*;
(
    input  logic              leg_wr,
    input  logic [BANK_W-1:0] leg_bank,
    output logic [SLOT_CNT-1:0] ovr_en,
    output page_vec_t         ovr_val
);

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
        if (s < ROM_SLOTS) begin : g_rom
            assign ovr_en[s]  = leg_wr;
            assign ovr_val[s] = page_t'(ROM_PAGE);
        end else if (s >= MIRROR_LO && s < MIRROR_LO + 2) begin : g_pair
            assign ovr_en[s]  = leg_wr;
            assign ovr_val[s] = {leg_bank, 1'(s - MIRROR_LO)};
        end else begin : g_none
            assign ovr_en[s]  = 1'b0;
            assign ovr_val[s] = '0;
        end
    end

endmodule

// File: rtl/slot_reg_bank.sv
module slot_reg_bank
    import slot_pager_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_wr,
    input  logic [SLOT_W-1:0]   idx_sel,
    input  page_t               idx_data,
    input  logic [SLOT_CNT-1:0] ovr_en,
    input  page_vec_t           ovr_val,
    output page_vec_t           slot_q
);

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= reset_page(s);
            else if (ovr_en[s])
                slot_q[s] <= ovr_val[s];
            else if (idx_wr && idx_sel == SLOT_W'(s))
                slot_q[s] <= idx_data;
        end
    end

    // R2: reset image
    p_reset_image_r2: assert property (@(posedge clk) rst |=> slot_q == reset_image());

    // R3: an indexed write that no override shadows lands next cycle
    p_idx_write_r3: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && !ovr_en[idx_sel]) |=> slot_q[$past(idx_sel)] == $past(idx_data));

    // R3: registers hold without any write
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!idx_wr && ovr_en == '0) |=> $stable(slot_q));

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import slot_pager_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  page_vec_t         slot_q,
    input  logic              cpu_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    output phys_t             phys,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              unmapped
);

    logic [SLOT_W-1:0] slot;
    page_t             pg;
    acc_kind_e         kind;

    assign slot = cpu_addr[CPU_AW-1 -: SLOT_W];
    assign pg   = slot_q[slot];

    always_comb begin
        phys.page = pg;
        phys.offs = cpu_addr[OFFS_W-1:0];
        kind      = cpu_req ? classify(pg, int'(slot) < ROM_SLOTS) : ACC_NONE;
        ram_sel   = (kind == ACC_RAM);
        rom_sel   = (kind == ACC_ROM);
        unmapped  = (kind == ACC_BAD);
    end

    // R9: no flag without a request
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> !(ram_sel || rom_sel || unmapped));

    // R6: a request raises exactly one flag
    p_one_kind_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> $countones({ram_sel, rom_sel, unmapped}) == 1);

    // R4: ROM only in the lowest windows
    p_rom_low_r4: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> (int'(slot) < ROM_SLOTS && int'(phys.page) == ROM_PAGE));

endmodule

// File: rtl/slot_pager.sv
module slot_pager
    import slot_pager_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SLOT_W-1:0] reg_idx,
    input  logic [PAGE_W-1:0] reg_wdata,
    output logic [PAGE_W-1:0] reg_rdata,
    input  logic              leg_wr,
    input  logic [BANK_W-1:0] leg_bank,
    input  logic              cpu_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              unmapped
);

    logic [SLOT_CNT-1:0] ovr_en;
    page_vec_t           ovr_val;
    page_vec_t           slot_q;
    phys_t               phys;

    bank_mirror u_mirror (
        .leg_wr   (leg_wr),
        .leg_bank (leg_bank),
        .ovr_en   (ovr_en),
        .ovr_val  (ovr_val)
    );

    slot_reg_bank u_regs (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (reg_wr),
        .idx_sel  (reg_idx),
        .idx_data (reg_wdata),
        .ovr_en   (ovr_en),
        .ovr_val  (ovr_val),
        .slot_q   (slot_q)
    );

    addr_xlate u_xlate (
        .clk      (clk),
        .rst      (rst),
        .slot_q   (slot_q),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .phys     (phys),
        .ram_sel  (ram_sel),
        .rom_sel  (rom_sel),
        .unmapped (unmapped)
    );

    assign reg_rdata = slot_q[reg_idx];
    assign phys_addr = phys;

    // R7: legacy write forces the low windows to the ROM page
    p_leg_rom_r7: assert property (@(posedge clk) disable iff (rst)
        leg_wr |=> (int'(slot_q[0]) == ROM_PAGE && int'(slot_q[1]) == ROM_PAGE));

    // R7: legacy write maps both halves of the bank
    p_leg_pair_r7: assert property (@(posedge clk) disable iff (rst)
        leg_wr |=> (slot_q[MIRROR_LO] == {$past(leg_bank), 1'b0} &&
                    slot_q[MIRROR_LO+1] == {$past(leg_bank), 1'b1}));

    // R7: middle windows are untouched by a legacy-only write
    p_leg_mid_r7: assert property (@(posedge clk) disable iff (rst)
        (leg_wr && !reg_wr) |=> slot_q[MIRROR_LO-1:ROM_SLOTS] == $past(slot_q[MIRROR_LO-1:ROM_SLOTS]));

endmodule

// File: tb/slot_pager_tb.sv
module slot_pager_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        leg_wr = 1'b0;
    logic [6:0]  leg_bank = '0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [20:0] phys_addr;
    logic        ram_sel, rom_sel, unmapped;

    int checks = 0;
    int errors = 0;
    int model [8];
    bit done = 0;

    always #5 clk = ~clk;

    slot_pager u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .leg_wr(leg_wr),
        .leg_bank(leg_bank), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .phys_addr(phys_addr), .ram_sel(ram_sel), .rom_sel(rom_sel),
        .unmapped(unmapped)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        model = '{255, 255, 10, 11, 4, 5, 0, 1};
    endtask

    // drive one cycle, compare against model, then advance the model at the edge
    task automatic step(input bit wr, input int idx, input int data,
                        input bit lw, input int lb, input bit req, input int addr,
                        input string rtag);
        int s, pg, expf;
        string ftag;
        reg_wr = wr; reg_idx = 3'(idx); reg_wdata = 8'(data);
        leg_wr = lw; leg_bank = 7'(lb); cpu_req = req; cpu_addr = 16'(addr);
        #1;
        s  = (addr >> 13) & 7;
        pg = model[s];
        chk(reg_rdata == 8'(model[idx]), rtag, reg_rdata, model[idx]);
        chk(phys_addr == 21'((pg << 13) | (addr & 16'h1fff)), "R1 phys", phys_addr,
            (pg << 13) | (addr & 16'h1fff));
        if (!req)                  begin expf = 0; ftag = "R9 flags"; end
        else if (pg < 224)         begin expf = 4; ftag = "R5 flags"; end
        else if (pg == 255 && s < 2) begin expf = 2; ftag = "R4 flags"; end
        else                       begin expf = 1; ftag = "R6 flags"; end
        chk({ram_sel, rom_sel, unmapped} == 3'(expf), ftag,
            {ram_sel, rom_sel, unmapped}, expf);
        @(posedge clk);
        if (wr) model[idx] = data;
        if (lw) begin
            model[0] = 255; model[1] = 255;
            model[6] = 2 * lb; model[7] = 2 * lb + 1;
        end
        @(negedge clk);
    endtask

    task automatic rd(input int idx, input string tag);
        step(0, idx, 0, 0, 0, 1, idx << 13 | 16'h0123, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset image via readback and translation
        for (int i = 0; i < 8; i++) rd(i, "R2 reset");

        // R9: idle request keeps flags low
        step(0, 0, 0, 0, 0, 0, 16'h4000, "R3 idle");

        // R3/R5/R6/R4: page boundary values
        step(1, 3, 223, 0, 0, 0, 0, "R3 wr");
        rd(3, "R3 rd223");
        step(1, 3, 224, 0, 0, 0, 0, "R3 wr");
        rd(3, "R3 rd224");
        step(1, 3, 254, 0, 0, 0, 0, "R3 wr");
        rd(3, "R3 rd254");
        step(1, 3, 255, 0, 0, 0, 0, "R3 wr");
        rd(3, "R3 rd255");
        step(1, 0, 7, 0, 0, 0, 0, "R3 wr");
        rd(0, "R3 rd0");
        step(1, 1, 255, 0, 0, 0, 0, "R3 wr");
        rd(1, "R4 rom1");
        step(1, 7, 0, 0, 0, 0, 0, "R3 wr");
        rd(7, "R3 rd7");

        // R7/R10: legacy write, readback of all windows
        step(0, 0, 0, 1, 5, 0, 0, "R7 pre");
        for (int i = 0; i < 8; i++) rd(i, "R10 legacy rb");
        step(0, 0, 0, 1, 127, 0, 0, "R7 pre");
        rd(6, "R7 top6");
        rd(7, "R7 top7");
        rd(2, "R7 mid");

        // R8: collisions
        step(1, 6, 9, 1, 3, 0, 0, "R8 pre");
        rd(6, "R8 legacy wins6");
        step(1, 0, 9, 1, 3, 0, 0, "R8 pre");
        rd(0, "R8 legacy wins0");
        step(1, 4, 200, 1, 8, 0, 0, "R8 pre");
        rd(4, "R8 mid lands");
        rd(7, "R8 pair");

        // mixed random traffic
        for (int n = 0; n < 2000; n++) begin
            int r = $urandom;
            step(r[0] & r[1], $urandom_range(0, 7), $urandom_range(0, 255),
                 (r[4:2] == 3'd0), $urandom_range(0, 127), r[5] | r[6],
                 $urandom_range(0, 65535), "R3 rand");
        end

        // R2: reset again mid-run
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(i, "R2 rereset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule